// File: doc/BRIEF.md
# Subsystem DMA Handshake Controller

This block sits between the message engine of a serial-bus remote terminal and the memory of the host subsystem. It moves data words across with a three-step handshake: it lowers a request, waits for the subsystem to lower its grant, then lowers its own acknowledge and drives the address and strobes. On a receive message, words from the core are written out either one at a time as each arrives, or held back and written as one contiguous run once the full expected count is in. On a transmit message, each word the core asks for is read from the subsystem and handed back to the core.

Every transfer uses a 5-bit word-count address that starts at zero with each message and steps by one after every completed transfer. If the grant fails to arrive within a set time after the request, the block raises a sticky active-low failure output and bit 12 of a built-in-test word. It also pulses an abort to the message engine and ignores the rest of the message. A new message start clears the failure.

The controller is one state machine: ST_IDLE, ST_REQ, ST_ACK, ST_STROBE and ST_FAIL. ST_IDLE goes to ST_REQ when a write is ready or a read is pending. ST_REQ goes to ST_ACK on grant, or to ST_FAIL when the timer expires. ST_ACK always goes to ST_STROBE. ST_STROBE and ST_FAIL always return to ST_IDLE. A message start forces ST_IDLE from any state.

Top module: `dma_hs_ctrl`

## Requirements
- R1: After reset, the request, acknowledge, write strobe and output enable are high, the failure output is high, bit 12 of the test word is 0 and the address is 0.
- R2: With per-word mode selected, each accepted receive word is written to the subsystem before the next one arrives if they are spaced by at least 8 cycles. Words are written in the order received.
- R3: In burst mode, no write occurs until the expected count of words has been accepted. Then all are written in order. Words beyond the expected count are ignored. A word-count field of 0 means 32 words.
- R4: The acknowledge falls only in the cycle after the grant was seen low while the request was low.
- R5: During a write, the read/transmit indicator is high and the output enable is high. The write strobe is low for exactly one cycle, with the acknowledge low.
- R6: During a read, the output enable is low for one cycle with the indicator low. The value on the subsystem read data is then presented on tx_data with tx_valid high for one cycle.
- R7: The address is 0 at each message start and steps by one, wrapping at 32, after each write or read.
- R8: If the grant stays high for TIMEOUT_NS worth of clocks after the request falls, the failure output goes low, bit 12 of the test word is set and msg_abort pulses for one cycle. A grant that arrives inside the window causes no failure.
- R9: After a failure, receive words and read requests of that message cause no transfer.
- R10: The failure output stays low until the next message start, which clears it and bit 12.
- R11: The broadcast and subaddress outputs hold steady from the acknowledge to the end of the strobe. They carry the values latched at message start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_start | input | 1 | One-cycle pulse: a valid command opens a new message |
| msg_is_tx | input | 1 | 1 = transmit message (reads), 0 = receive message (writes) |
| msg_burst | input | 1 | 1 = burst write mode, 0 = per-word write mode |
| msg_wc | input | 5 | Expected word count, 0 means 32 |
| msg_bcast | input | 1 | Broadcast flag of the command |
| msg_subaddr | input | 5 | Subaddress of the command |
| rx_valid | input | 1 | A received data word is present |
| rx_data | input | 16 | Received data word |
| tx_req | input | 1 | Core asks for the next transmit word |
| tx_valid | output | 1 | One-cycle pulse: tx_data holds a read word |
| tx_data | output | 16 | Word read from the subsystem |
| msg_abort | output | 1 | One-cycle pulse: handshake failure, abort the message |
| dma_req_n | output | 1 | Active-low transfer request |
| dma_grant_n | input | 1 | Active-low grant from the subsystem |
| dma_ack_n | output | 1 | Active-low acknowledge |
| ss_rd_tx | output | 1 | High for a write to the subsystem, low for a read |
| ss_oe_n | output | 1 | Active-low output enable for reads |
| ss_wr_n | output | 1 | Active-low one-cycle write strobe |
| ss_addr | output | 5 | Word-count address |
| ss_bcast | output | 1 | Broadcast flag toward the subsystem |
| ss_subaddr | output | 5 | Subaddress toward the subsystem |
| ss_wdata | output | 16 | Write data |
| ss_rdata | input | 16 | Read data from the subsystem |
| hs_fail_n | output | 1 | Active-low sticky handshake failure |
| bit_word | output | 16 | Built-in-test word, bit 12 = handshake failure |

## Verification
Two things can fall in the same cycle in per-word mode. A new receive word may be pushed into the word buffer in the very cycle the strobe pops the oldest one. The bench provokes this by sending five words in consecutive cycles while the grant is given at once, so pushes land during ST_STROBE. The scoreboard judges it by requiring every write to show the expected data, address, broadcast flag and subaddress, in order and with nothing lost or repeated.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ACK,
        ST_STROBE,
        ST_FAIL
    } dma_state_e;

    localparam int BIT_HSF_POS = 12;
    localparam int BIT_WORD_W  = 16;

endpackage

// File: rtl/dma_hs_wbuf.sv
module dma_hs_wbuf #(
    parameter int W     = 16,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [AW:0]   cnt_q;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == (AW+1)'(DEPTH));
    assign dout  = mem[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wr_ptr_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) begin
                wr_ptr_q <= wr_ptr_q + 1'b1;
            end
            if (pop && !empty) begin
                rd_ptr_q <= rd_ptr_q + 1'b1;
            end
            case ({push, pop && !empty})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !pop && !flush))
        else $error("word buffer pushed while full");

    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> !empty)
        else $error("word buffer popped while empty");

endmodule

// File: rtl/dma_hs_timeout.sv
module dma_hs_timeout #(
    parameter int LIMIT = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT - 1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == CW'(LIMIT - 1));

    p_cnt_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT - 1))
        else $error("timeout counter beyond limit");

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0)
        else $error("timeout counter not restarted");

endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
    import dma_hs_pkg::*;
#(
    parameter int DW         = 16,
    parameter int AW         = 5,
    parameter int SA_W       = 5,
    parameter int CLK_HZ     = 50_000_000,
    parameter int TIMEOUT_NS = 10_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            msg_start,
    input  logic            msg_is_tx,
    input  logic            msg_burst,
    input  logic [AW-1:0]   msg_wc,
    input  logic            msg_bcast,
    input  logic [SA_W-1:0] msg_subaddr,
    input  logic            rx_valid,
    input  logic [DW-1:0]   rx_data,
    input  logic            tx_req,
    output logic            tx_valid,
    output logic [DW-1:0]   tx_data,
    output logic            msg_abort,
    output logic            dma_req_n,
    input  logic            dma_grant_n,
    output logic            dma_ack_n,
    output logic            ss_rd_tx,
    output logic            ss_oe_n,
    output logic            ss_wr_n,
    output logic [AW-1:0]   ss_addr,
    output logic            ss_bcast,
    output logic [SA_W-1:0] ss_subaddr,
    output logic [DW-1:0]   ss_wdata,
    input  logic [DW-1:0]   ss_rdata,
    output logic            hs_fail_n,
    output logic [BIT_WORD_W-1:0] bit_word
);
    localparam int DEPTH  = 1 << AW;
    localparam int TO_CYC = ((CLK_HZ / 1000) * (TIMEOUT_NS / 10)) / 100_000;
    localparam int LIMIT  = (TO_CYC < 2) ? 2 : TO_CYC;

    dma_state_e state_q, state_d;

    logic            is_tx_q, burst_q, live_q, burst_go_q, fail_q;
    logic [AW:0]     exp_cnt_q, rx_cnt_q, tx_pend_q;
    logic [AW-1:0]   addr_q;
    logic            bcast_q;
    logic [SA_W-1:0] sa_q;
    logic            tx_valid_q, abort_q;
    logic [DW-1:0]   tx_data_q;

    logic accept_rx, write_ready, read_ready, fail_evt, tmr_exp;
    logic buf_empty, buf_full, buf_pop, buf_flush, strobe_done;
    logic [DW-1:0] buf_dout;

    assign accept_rx   = rx_valid && live_q && !is_tx_q && !msg_start
                         && (rx_cnt_q < exp_cnt_q);
    assign write_ready = !is_tx_q && !buf_empty && (!burst_q || burst_go_q);
    assign read_ready  = is_tx_q && (tx_pend_q != '0);
    assign fail_evt    = (state_q == ST_REQ) && dma_grant_n && tmr_exp && !msg_start;
    assign strobe_done = (state_q == ST_STROBE) && !msg_start;
    assign buf_pop     = strobe_done && !is_tx_q;
    assign buf_flush   = msg_start || fail_evt;

    dma_hs_wbuf #(.W(DW), .DEPTH(DEPTH)) u_wbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (buf_flush),
        .push  (accept_rx),
        .din   (rx_data),
        .pop   (buf_pop),
        .dout  (buf_dout),
        .empty (buf_empty),
        .full  (buf_full)
    );

    dma_hs_timeout #(.LIMIT(LIMIT)) u_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_REQ),
        .expired (tmr_exp)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (live_q && (write_ready || read_ready)) begin
                    state_d = ST_REQ;
                end
            end
            ST_REQ: begin
                if (!dma_grant_n) begin
                    state_d = ST_ACK;
                end else if (tmr_exp) begin
                    state_d = ST_FAIL;
                end
            end
            ST_ACK:    state_d = ST_STROBE;
            ST_STROBE: state_d = ST_IDLE;
            ST_FAIL:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (msg_start) begin
            state_d = ST_IDLE;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        dma_req_n = 1'b1;
        dma_ack_n = 1'b1;
        ss_wr_n   = 1'b1;
        ss_oe_n   = 1'b1;
        unique case (state_q)
            ST_REQ: dma_req_n = 1'b0;
            ST_ACK: begin
                dma_req_n = 1'b0;
                dma_ack_n = 1'b0;
            end
            ST_STROBE: begin
                dma_req_n = 1'b0;
                dma_ack_n = 1'b0;
                ss_wr_n   = is_tx_q;
                ss_oe_n   = !is_tx_q;
            end
            ST_IDLE, ST_FAIL: ;
            default: ;
        endcase
        ss_rd_tx   = !is_tx_q;
        ss_addr    = addr_q;
        ss_bcast   = bcast_q;
        ss_subaddr = sa_q;
        ss_wdata   = buf_dout;
        tx_valid   = tx_valid_q;
        tx_data    = tx_data_q;
        msg_abort  = abort_q;
        hs_fail_n  = !fail_q;
        bit_word   = '0;
        bit_word[BIT_HSF_POS] = fail_q;
    end

    // Message context and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_tx_q    <= 1'b0;
            burst_q    <= 1'b0;
            live_q     <= 1'b0;
            burst_go_q <= 1'b0;
            fail_q     <= 1'b0;
            exp_cnt_q  <= '0;
            rx_cnt_q   <= '0;
            tx_pend_q  <= '0;
            addr_q     <= '0;
            bcast_q    <= 1'b0;
            sa_q       <= '0;
            tx_valid_q <= 1'b0;
            tx_data_q  <= '0;
            abort_q    <= 1'b0;
        end else begin
            tx_valid_q <= is_tx_q && strobe_done;
            abort_q    <= fail_evt;
            if (is_tx_q && strobe_done) begin
                tx_data_q <= ss_rdata;
            end
            if (msg_start) begin
                is_tx_q    <= msg_is_tx;
                burst_q    <= msg_burst;
                live_q     <= 1'b1;
                burst_go_q <= 1'b0;
                fail_q     <= 1'b0;
                exp_cnt_q  <= (msg_wc == '0) ? (AW+1)'(DEPTH) : {1'b0, msg_wc};
                rx_cnt_q   <= '0;
                tx_pend_q  <= '0;
                addr_q     <= '0;
                bcast_q    <= msg_bcast;
                sa_q       <= msg_subaddr;
            end else begin
                if (accept_rx) begin
                    rx_cnt_q <= rx_cnt_q + 1'b1;
                    if (rx_cnt_q + 1'b1 == exp_cnt_q) begin
                        burst_go_q <= 1'b1;
                    end
                end
                if (strobe_done) begin
                    addr_q <= addr_q + 1'b1;
                end
                if (fail_evt) begin
                    fail_q    <= 1'b1;
                    live_q    <= 1'b0;
                    tx_pend_q <= '0;
                end else begin
                    case ({tx_req && is_tx_q && live_q, is_tx_q && strobe_done})
                        2'b10:   tx_pend_q <= tx_pend_q + 1'b1;
                        2'b01:   tx_pend_q <= tx_pend_q - 1'b1;
                        default: tx_pend_q <= tx_pend_q;
                    endcase
                end
            end
        end
    end

    p_ack_after_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_ack_n) |-> $past(!dma_grant_n) && $past(!dma_req_n))
        else $error("acknowledge without grant");

    p_wr_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_wr_n |=> ss_wr_n)
        else $error("write strobe longer than one cycle");

    p_write_levels_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_wr_n |-> ss_oe_n && ss_rd_tx && !dma_ack_n)
        else $error("write strobe with wrong side signals");

    p_oe_levels_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_oe_n |=> ss_oe_n)
        else $error("output enable longer than one cycle");

    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ss_wr_n || !ss_oe_n) && !msg_start) |=> ss_addr == $past(ss_addr) + 1'b1)
        else $error("address did not step after transfer");

    p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_fail_n && !msg_start) |=> !hs_fail_n)
        else $error("failure output released early");

    p_fail_no_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_fail_n |-> ss_wr_n && ss_oe_n)
        else $error("transfer while failed");

    p_sa_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_ack_n && $past(!dma_ack_n) && !$past(msg_start))
        |-> $stable(ss_subaddr) && $stable(ss_bcast))
        else $error("subaddress moved during transfer");

endmodule

// File: tb/dma_hs_ctrl_bench.sv
module dma_hs_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TO_CYCLES  = 50;   // 5 MHz * 10 us

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_start = 1'b0, msg_is_tx = 1'b0, msg_burst = 1'b0;
    logic [4:0]  msg_wc = '0;
    logic        msg_bcast = 1'b0;
    logic [4:0]  msg_subaddr = '0;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_data = '0;
    logic        tx_req = 1'b0;
    logic        tx_valid, msg_abort, dma_req_n, dma_ack_n;
    logic        ss_rd_tx, ss_oe_n, ss_wr_n, ss_bcast, hs_fail_n;
    logic [15:0] tx_data, ss_wdata, ss_rdata, bit_word;
    logic [4:0]  ss_addr, ss_subaddr;
    logic        dma_grant_n;
    logic        grant_en = 1'b1;

    int n_tests = 0, n_fail = 0;
    int wr_cnt = 0, rd_cnt = 0, abort_cnt = 0;
    int exp_addr = 0;
    logic        cur_bcast = 1'b0;
    logic [4:0]  cur_sa = '0;
    logic [26:0] wr_q [$];
    logic [15:0] rd_q [$];
    logic        prev_wr_n = 1'b1, prev_oe_n = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign dma_grant_n = !(grant_en && !dma_req_n);
    assign ss_rdata    = 16'hA500 ^ {11'd0, ss_addr};

    dma_hs_ctrl #(.CLK_HZ(5_000_000), .TIMEOUT_NS(10_000)) u_dma_hs_ctrl (
        .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_is_tx(msg_is_tx),
        .msg_burst(msg_burst), .msg_wc(msg_wc), .msg_bcast(msg_bcast),
        .msg_subaddr(msg_subaddr), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_req(tx_req), .tx_valid(tx_valid), .tx_data(tx_data),
        .msg_abort(msg_abort), .dma_req_n(dma_req_n), .dma_grant_n(dma_grant_n),
        .dma_ack_n(dma_ack_n), .ss_rd_tx(ss_rd_tx), .ss_oe_n(ss_oe_n),
        .ss_wr_n(ss_wr_n), .ss_addr(ss_addr), .ss_bcast(ss_bcast),
        .ss_subaddr(ss_subaddr), .ss_wdata(ss_wdata), .ss_rdata(ss_rdata),
        .hs_fail_n(hs_fail_n), .bit_word(bit_word)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: compares subsystem-side activity with the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ss_wr_n) begin
                logic [26:0] got, want;
                wr_cnt++;
                got = {ss_subaddr, ss_bcast, ss_addr, ss_wdata};
                check(prev_wr_n && ss_oe_n && ss_rd_tx && !dma_ack_n, "R5 write levels",
                      {28'd0, prev_wr_n, ss_oe_n, ss_rd_tx, dma_ack_n}, 32'hE);
                if (wr_q.size() == 0) begin
                    check(1'b0, "R2 unexpected write", {5'd0, got}, 32'h0);
                end else begin
                    want = wr_q.pop_front();
                    check(got == want, "R2/R7/R11 write item", {5'd0, got}, {5'd0, want});
                end
            end
            if (!ss_oe_n) begin
                check(prev_oe_n && !ss_rd_tx && ss_wr_n, "R6 read levels",
                      {29'd0, prev_oe_n, ss_rd_tx, ss_wr_n}, 32'h5);
            end
            if (tx_valid) begin
                logic [15:0] want16;
                rd_cnt++;
                if (rd_q.size() == 0) begin
                    check(1'b0, "R6 unexpected read word", {16'd0, tx_data}, 32'h0);
                end else begin
                    want16 = rd_q.pop_front();
                    check(tx_data == want16, "R6/R7 read word", {16'd0, tx_data}, {16'd0, want16});
                end
            end
            if (msg_abort) abort_cnt++;
            prev_wr_n = ss_wr_n;
            prev_oe_n = ss_oe_n;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_msg(input logic tx, input logic burst, input logic [4:0] wc,
                             input logic bc, input logic [4:0] sa);
        @(negedge clk);
        msg_start = 1'b1; msg_is_tx = tx; msg_burst = burst; msg_wc = wc;
        msg_bcast = bc; msg_subaddr = sa;
        cur_bcast = bc; cur_sa = sa; exp_addr = 0;
        @(negedge clk);
        msg_start = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] d, input logic expect_it);
        if (expect_it) begin
            wr_q.push_back({cur_sa, cur_bcast, 5'(exp_addr), d});
            exp_addr = (exp_addr + 1) % 32;
        end
        rx_valid = 1'b1; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic ask_read(input logic expect_it);
        if (expect_it) begin
            rd_q.push_back(16'hA500 ^ {11'd0, 5'(exp_addr)});
            exp_addr = (exp_addr + 1) % 32;
        end
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int base, cnt;
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(dma_req_n && dma_ack_n && ss_wr_n && ss_oe_n, "R1 strobes idle",
              {28'd0, dma_req_n, dma_ack_n, ss_wr_n, ss_oe_n}, 32'hF);
        check(hs_fail_n && !bit_word[12] && ss_addr == 0, "R1 fail/addr",
              {15'd0, hs_fail_n, bit_word}, {15'd0, 1'b1, 16'h0});

        // R2 per-word writes, each done before the next word
        start_msg(1'b0, 1'b0, 5'd4, 1'b0, 5'd7);
        for (int i = 0; i < 4; i++) begin
            base = wr_cnt;
            send_word(16'h1100 + 16'(i), 1'b1);
            cycles(8);
            check(wr_cnt == base + 1, "R2 written before next word", wr_cnt, base + 1);
        end
        check(ss_addr == 5'd4, "R7 address after four writes", ss_addr, 4);

        // R2 back-to-back words: push collides with strobe pop
        start_msg(1'b0, 1'b0, 5'd5, 1'b1, 5'd19);
        check(ss_addr == 0, "R7 address cleared at message start", ss_addr, 0);
        for (int i = 0; i < 5; i++) send_word(16'h2200 + 16'(i), 1'b1);
        cycles(30);
        check(wr_q.size() == 0, "R2 all back-to-back words written", wr_q.size(), 0);

        // R3 burst: nothing until count reached, extra word ignored
        start_msg(1'b0, 1'b1, 5'd3, 1'b0, 5'd2);
        base = wr_cnt;
        send_word(16'h3300, 1'b1);
        send_word(16'h3301, 1'b1);
        cycles(20);
        check(wr_cnt == base, "R3 no write before full count", wr_cnt, base);
        send_word(16'h3302, 1'b1);
        cycles(20);
        check(wr_cnt == base + 3, "R3 burst written", wr_cnt, base + 3);
        send_word(16'h3303, 1'b0);
        cycles(20);
        check(wr_cnt == base + 3, "R3 word beyond count ignored", wr_cnt, base + 3);

        // R3 / R7: count field 0 means 32, address wraps
        start_msg(1'b0, 1'b1, 5'd0, 1'b1, 5'd31);
        base = wr_cnt;
        for (int i = 0; i < 31; i++) send_word(16'h4000 + 16'(i), 1'b1);
        cycles(10);
        check(wr_cnt == base, "R3 31 of 32 held back", wr_cnt, base);
        send_word(16'h401F, 1'b1);
        cycles(32 * 4 + 10);
        check(wr_cnt == base + 32, "R3 32 words burst", wr_cnt, base + 32);
        check(ss_addr == 0, "R7 address wraps to 0", ss_addr, 0);

        // R6 reads
        start_msg(1'b1, 1'b0, 5'd3, 1'b0, 5'd9);
        base = rd_cnt;
        ask_read(1'b1);
        cycles(8);
        ask_read(1'b1);
        ask_read(1'b1);
        cycles(16);
        check(rd_cnt == base + 3, "R6 three words read", rd_cnt, base + 3);

        // R8 late grant inside window: no failure
        start_msg(1'b0, 1'b0, 5'd2, 1'b0, 5'd1);
        grant_en = 1'b0;
        send_word(16'h5500, 1'b1);
        cycles(40);
        grant_en = 1'b1;
        cycles(10);
        check(hs_fail_n && wr_q.size() == 0, "R8 late grant accepted",
              {31'd0, hs_fail_n}, 1);

        // R8 write timeout, exact window length
        start_msg(1'b0, 1'b0, 5'd4, 1'b0, 5'd3);
        grant_en = 1'b0;
        base = abort_cnt;
        send_word(16'h6600, 1'b0);
        cnt = 0;
        for (int g = 0; g < 200 && hs_fail_n; g++) begin
            if (!dma_req_n) cnt++;
            @(negedge clk);
        end
        check(cnt == TO_CYCLES, "R8 request cycles before failure", cnt, TO_CYCLES);
        check(!hs_fail_n && bit_word[12], "R8 failure and test bit",
              {15'd0, hs_fail_n, bit_word}, {15'd0, 1'b0, 16'h1000});
        cycles(2);
        check(abort_cnt == base + 1, "R8 one abort pulse", abort_cnt, base + 1);

        // R9 words after failure are ignored
        grant_en = 1'b1;
        base = wr_cnt;
        send_word(16'h6601, 1'b0);
        cycles(15);
        check(wr_cnt == base && dma_req_n, "R9 no transfer after failure", wr_cnt, base);
        check(!hs_fail_n, "R10 failure still held", {31'd0, hs_fail_n}, 0);

        // R10 cleared by next message start
        start_msg(1'b0, 1'b0, 5'd1, 1'b0, 5'd4);
        check(hs_fail_n && !bit_word[12], "R10 cleared at message start",
              {15'd0, hs_fail_n, bit_word}, {15'd0, 1'b1, 16'h0});
        send_word(16'h7700, 1'b1);
        cycles(10);

        // R8 read timeout aborts transmit message
        start_msg(1'b1, 1'b0, 5'd2, 1'b0, 5'd5);
        grant_en = 1'b0;
        base = abort_cnt;
        ask_read(1'b0);
        cycles(TO_CYCLES + 10);
        check(!hs_fail_n && abort_cnt == base + 1, "R8 read timeout aborts",
              abort_cnt, base + 1);
        grant_en = 1'b1;
        base = rd_cnt;
        ask_read(1'b0);
        cycles(10);
        check(rd_cnt == base, "R9 read request ignored after failure", rd_cnt, base);

        check(wr_q.size() == 0 && rd_q.size() == 0, "R2/R6 scoreboard drained",
              wr_q.size() + rd_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule